// File: doc/BRIEF.md
# Branch Target Buffer with Stored Target

This block is a direct-mapped buffer of branch records for an instruction fetch unit. Each record keeps a valid flag, the full address of a branch instruction, the address that branch jumped to on its most recent taken execution, and a two-bit direction state. On the lookup side, fetch offers its current PC and gets back, in the same cycle, whether a record matches, whether that record predicts a taken branch, the stored target and the next fetch address. That address is the stored target when the prediction is taken, so fetch can start on the target path before the branch reaches execution. This matters most for indirect branches, whose destination is unknown until they execute.

On the resolve side, the execute stage reports each finished branch with its PC, its real direction and its real destination. The block states at once whether the earlier prediction for that branch was wrong, and it updates the record on the next clock edge. The direction state only changes its prediction after two wrong guesses in a row.

Top module: `branch_target_buffer`

## Requirements
- R1: After synchronous reset every record is invalid: any lookup reports lkHit=0, lkTaken=0, lkRedirect=0, lkTarget=0 and lkNextPc=lkPc+4.
- R2: A lookup hits when the record at index lkPc[IDX_W+1:2] is valid and its stored address equals lkPc in full. On a hit lkTarget is the stored target and lkTaken is the upper state bit. On a miss lkTaken=0 and lkTarget=0.
- R3: The state is {prediction, last outcome} with 1 meaning taken. The transitions are 00 -nt-> 00, 00 -t-> 01, 01 -nt-> 00, 01 -t-> 11, 11 -t-> 11, 11 -nt-> 10, 10 -t-> 11, 10 -nt-> 00. So the predicted direction flips only after two wrong predictions in a row.
- R4: After any resolve, the lower state bit of the written record equals the resolved outcome.
- R5: A resolve that misses overwrites the record at its index with valid=1, the resolved PC, the resolved target, and state {outcome, outcome}. This also evicts a different branch that shares the index.
- R6: A resolve that hits rewrites the stored target with the actual target only when the branch was taken. A not-taken resolve leaves the stored target unchanged.
- R7: lkRedirect is 1 exactly when the lookup hits and predicts taken. lkNextPc is lkTarget when lkRedirect=1 and lkPc+4 otherwise.
- R8: rsMispredict is combinational while rsValid=1. On a hit it is 1 if the predicted direction differs from rsTaken, or if rsTaken=1 and the stored target differs from rsTarget. On a miss it equals rsTaken. It is 0 when rsValid=0.
- R9: Lookup reads the contents as they stood before the current clock edge. A resolve becomes visible to lookups from the cycle after it is presented, including a lookup of the same PC in the same cycle as the resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears all valid flags |
| lkPc | input | PC_W | Fetch PC being looked up |
| lkHit | output | 1 | A valid record matches lkPc |
| lkTaken | output | 1 | The matching record predicts taken |
| lkTarget | output | PC_W | Stored target of the matching record, zero on a miss |
| lkRedirect | output | 1 | Fetch should jump to lkTarget |
| lkNextPc | output | PC_W | Next fetch address |
| rsValid | input | 1 | A resolved branch is presented this cycle |
| rsPc | input | PC_W | Address of the resolved branch |
| rsTaken | input | 1 | Actual direction of the resolved branch |
| rsTarget | input | PC_W | Actual destination of the resolved branch |
| rsMispredict | output | 1 | The prediction for the resolved branch was wrong |

## Verification
The assertions assume that rsPc and rsTarget are meaningful only while rsValid is high, and that resolve reports arrive in any order relative to lookups of the same PC. They also assume that PCs are word aligned, so the two low bits never affect indexing. The stimulus drives only aligned addresses and holds rsValid low between reports. It deliberately places lookup and resolve of the same branch in one cycle, and it uses PCs that alias to the same index, so that eviction and the read-before-write order are exercised within those assumptions.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    ST_NT_NT = 2'b00,
    ST_NT_T  = 2'b01,
    ST_T_NT  = 2'b10,
    ST_T_T   = 2'b11
  } predState_t;

  typedef struct packed {
    logic       wrEn;
    logic       wrTag;
    logic       wrTarget;
    predState_t newState;
  } btbStrobe_t;

endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lkIdx,
  input  logic [IDX_W-1:0] rsIdx,
  input  logic [PC_W-1:0]  rsPc,
  input  logic [PC_W-1:0]  rsTarget,
  input  btbStrobe_t       strobe,
  output logic             lkValid,
  output logic [PC_W-1:0]  lkTag,
  output logic [PC_W-1:0]  lkTgt,
  output predState_t       lkState,
  output logic             rsEntValid,
  output logic [PC_W-1:0]  rsTag,
  output logic [PC_W-1:0]  rsTgt,
  output predState_t       rsState
);

  logic [DEPTH-1:0] validQ;
  logic [PC_W-1:0]  tagQ    [DEPTH];
  logic [PC_W-1:0]  targetQ [DEPTH];
  predState_t       stateQ  [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else if (strobe.wrTag) begin
      validQ[rsIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrTag)    tagQ[rsIdx]    <= rsPc;
    if (strobe.wrTarget) targetQ[rsIdx] <= rsTarget;
    if (strobe.wrEn)     stateQ[rsIdx]  <= strobe.newState;
  end

  assign lkValid    = validQ[lkIdx];
  assign lkTag      = tagQ[lkIdx];
  assign lkTgt      = targetQ[lkIdx];
  assign lkState    = stateQ[lkIdx];
  assign rsEntValid = validQ[rsIdx];
  assign rsTag      = tagQ[rsIdx];
  assign rsTgt      = targetQ[rsIdx];
  assign rsState    = stateQ[rsIdx];

  // R5: an allocation leaves a valid record holding the resolved PC
  a_r5_alloc_record: assert property (@(posedge clk) disable iff (rst)
    strobe.wrTag |=> validQ[$past(rsIdx)] && (tagQ[$past(rsIdx)] == $past(rsPc)));

  // R6: a write without a target strobe keeps the old target
  a_r6_target_hold: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrEn && !strobe.wrTarget) |=> (targetQ[$past(rsIdx)] == $past(rsTgt)));

  // R4: the stored state follows the strobe on the next edge
  a_r4_state_written: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |=> (stateQ[$past(rsIdx)] == $past(strobe.newState)));

endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  lkPc,
  input  logic             rsValid,
  input  logic [PC_W-1:0]  rsPc,
  input  logic             rsTaken,
  input  logic [PC_W-1:0]  rsTarget,
  input  logic             lkValid,
  input  logic [PC_W-1:0]  lkTag,
  input  logic [PC_W-1:0]  lkTgt,
  input  predState_t       lkState,
  input  logic             rsEntValid,
  input  logic [PC_W-1:0]  rsTag,
  input  logic [PC_W-1:0]  rsTgt,
  input  predState_t       rsState,
  output logic [IDX_W-1:0] lkIdx,
  output logic [IDX_W-1:0] rsIdx,
  output btbStrobe_t       strobe,
  output logic             lkHit,
  output logic             lkTaken,
  output logic [PC_W-1:0]  lkTarget,
  output logic             lkRedirect,
  output logic [PC_W-1:0]  lkNextPc,
  output logic             rsMispredict
);

  logic       rsHit;
  logic       predDir;
  logic       lastDir;
  logic       flipDir;
  predState_t hitNext;

  assign lkIdx = lkPc[IDX_W+1:2];
  assign rsIdx = rsPc[IDX_W+1:2];

  // lookup side
  assign lkHit      = lkValid && (lkTag == lkPc);
  assign lkTaken    = lkHit && lkState[1];
  assign lkTarget   = lkHit ? lkTgt : '0;
  assign lkRedirect = lkTaken;
  assign lkNextPc   = lkRedirect ? lkTarget : lkPc + PC_W'(4);

  // resolve side
  assign rsHit   = rsEntValid && (rsTag == rsPc);
  assign predDir = rsState[1];
  assign lastDir = rsState[0];
  // flip only if this guess is wrong and the previous outcome was wrong too
  assign flipDir = (rsTaken != predDir) && (lastDir == rsTaken);
  assign hitNext = predState_t'({flipDir ? rsTaken : predDir, rsTaken});

  always_comb begin
    strobe.wrEn     = rsValid;
    strobe.wrTag    = rsValid && !rsHit;
    strobe.wrTarget = rsValid && (!rsHit || rsTaken);
    strobe.newState = rsHit ? hitNext : predState_t'({rsTaken, rsTaken});
  end

  always_comb begin
    if (!rsValid)    rsMispredict = 1'b0;
    else if (!rsHit) rsMispredict = rsTaken;
    else             rsMispredict = (predDir != rsTaken) || (rsTaken && (rsTgt != rsTarget));
  end

  // R3: a settled state (prediction equals last outcome) never flips on one resolve
  a_r3_no_single_flip: assert property (@(posedge clk) disable iff (rst)
    (rsValid && rsHit && (rsState[1] == rsState[0])) |-> (strobe.newState[1] == rsState[1]));

  // R4: the lower state bit records the resolved outcome
  a_r4_last_outcome: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |-> (strobe.newState[0] == rsTaken));

  // R7: a redirect always points fetch at the stored target
  a_r7_redirect_target: assert property (@(posedge clk) disable iff (rst)
    lkRedirect |-> (lkHit && (lkNextPc == lkTgt)));

  // R8: a correct guess on a hit target match never reports a mispredict
  a_r8_clean_resolve: assert property (@(posedge clk) disable iff (rst)
    (rsValid && rsHit && (rsState[1] == rsTaken) && (!rsTaken || rsTgt == rsTarget)) |-> !rsMispredict);

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lkPc,
  output logic            lkHit,
  output logic            lkTaken,
  output logic [PC_W-1:0] lkTarget,
  output logic            lkRedirect,
  output logic [PC_W-1:0] lkNextPc,
  input  logic            rsValid,
  input  logic [PC_W-1:0] rsPc,
  input  logic            rsTaken,
  input  logic [PC_W-1:0] rsTarget,
  output logic            rsMispredict
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] rsIdx;
  btbStrobe_t       strobe;
  logic             lkValid;
  logic [PC_W-1:0]  lkTag;
  logic [PC_W-1:0]  lkTgt;
  predState_t       lkState;
  logic             rsEntValid;
  logic [PC_W-1:0]  rsTag;
  logic [PC_W-1:0]  rsTgt;
  predState_t       rsState;

  btb_ctrl #(.PC_W(PC_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .lkPc(lkPc), .rsValid(rsValid), .rsPc(rsPc), .rsTaken(rsTaken), .rsTarget(rsTarget),
    .lkValid(lkValid), .lkTag(lkTag), .lkTgt(lkTgt), .lkState(lkState),
    .rsEntValid(rsEntValid), .rsTag(rsTag), .rsTgt(rsTgt), .rsState(rsState),
    .lkIdx(lkIdx), .rsIdx(rsIdx), .strobe(strobe),
    .lkHit(lkHit), .lkTaken(lkTaken), .lkTarget(lkTarget),
    .lkRedirect(lkRedirect), .lkNextPc(lkNextPc), .rsMispredict(rsMispredict)
  );

  btb_datapath #(.PC_W(PC_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst),
    .lkIdx(lkIdx), .rsIdx(rsIdx), .rsPc(rsPc), .rsTarget(rsTarget), .strobe(strobe),
    .lkValid(lkValid), .lkTag(lkTag), .lkTgt(lkTgt), .lkState(lkState),
    .rsEntValid(rsEntValid), .rsTag(rsTag), .rsTgt(rsTgt), .rsState(rsState)
  );

  // R7: without a redirect fetch falls through to the next word
  a_r7_fallthrough: assert property (@(posedge clk) disable iff (rst)
    !lkRedirect |-> (lkNextPc == lkPc + PC_W'(4)));

endmodule

// File: tb/branch_target_buffer_tb.sv
`timescale 1ns/1ps
module branch_target_buffer_tb;

  localparam int PC_W  = 32;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);

  logic            clk = 1'b0;
  logic            rst;
  logic [PC_W-1:0] lkPc;
  logic            lkHit, lkTaken, lkRedirect, rsMispredict;
  logic [PC_W-1:0] lkTarget, lkNextPc;
  logic            rsValid;
  logic [PC_W-1:0] rsPc;
  logic            rsTaken;
  logic [PC_W-1:0] rsTarget;

  always #2.5 clk = ~clk;

  branch_target_buffer #(.PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .lkPc(lkPc), .lkHit(lkHit), .lkTaken(lkTaken),
    .lkTarget(lkTarget), .lkRedirect(lkRedirect), .lkNextPc(lkNextPc),
    .rsValid(rsValid), .rsPc(rsPc), .rsTaken(rsTaken), .rsTarget(rsTarget),
    .rsMispredict(rsMispredict)
  );

  typedef struct {
    string           req;
    logic            hit;
    logic            taken;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] nextPc;
    logic            mis;
  } expItem_t;

  expItem_t expQ[$];
  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // reference records, kept from the requirements
  logic            refValid [DEPTH];
  logic [PC_W-1:0] refPc    [DEPTH];
  logic [PC_W-1:0] refTgt   [DEPTH];
  logic [1:0]      refSt    [DEPTH];

  // R3 transition table written out state by state
  function automatic logic [1:0] nextSt(input logic [1:0] s, input logic t);
    case ({s, t})
      3'b000: return 2'b00;
      3'b001: return 2'b01;
      3'b010: return 2'b00;
      3'b011: return 2'b11;
      3'b100: return 2'b00;
      3'b101: return 2'b11;
      3'b110: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  task automatic cmp(input string req, input string what, input logic [PC_W-1:0] act,
                     input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: presents one cycle of stimulus and queues the expected outputs
  task automatic step(input logic [PC_W-1:0] lp, input logic rv, input logic [PC_W-1:0] rp,
                      input logic rt, input logic [PC_W-1:0] rg, input string req);
    expItem_t e;
    int li, ri;
    logic rh;
    @(posedge clk);
    #1;
    lkPc = lp; rsValid = rv; rsPc = rp; rsTaken = rt; rsTarget = rg;
    li = int'(lp[IDX_W+1:2]);
    ri = int'(rp[IDX_W+1:2]);
    e.req    = req;
    e.hit    = refValid[li] && (refPc[li] == lp);
    e.taken  = e.hit && refSt[li][1];
    e.target = e.hit ? refTgt[li] : '0;
    e.nextPc = e.taken ? e.target : lp + 4;
    rh = refValid[ri] && (refPc[ri] == rp);
    if (!rv)      e.mis = 1'b0;
    else if (!rh) e.mis = rt;
    else          e.mis = (refSt[ri][1] != rt) || (rt && refTgt[ri] != rg);
    expQ.push_back(e);
    if (rv) begin
      if (!rh) begin
        refValid[ri] = 1'b1; refPc[ri] = rp; refTgt[ri] = rg; refSt[ri] = {rt, rt};
      end else begin
        if (rt) refTgt[ri] = rg;
        refSt[ri] = nextSt(refSt[ri], rt);
      end
    end
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      cmp(e.req, "lkHit",        PC_W'(lkHit),        PC_W'(e.hit));
      cmp(e.req, "lkTaken",      PC_W'(lkTaken),      PC_W'(e.taken));
      cmp(e.req, "lkTarget",     lkTarget,            e.target);
      cmp(e.req, "lkRedirect",   PC_W'(lkRedirect),   PC_W'(e.taken));
      cmp(e.req, "lkNextPc",     lkNextPc,            e.nextPc);
      cmp(e.req, "rsMispredict", PC_W'(rsMispredict), PC_W'(e.mis));
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
        finishRun();
      end
    end
  end

  localparam logic [PC_W-1:0] A = 32'h0000_1000;
  localparam logic [PC_W-1:0] B = 32'h0000_1040;  // same index as A
  localparam logic [PC_W-1:0] C = 32'h0000_2008;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      refValid[i] = 1'b0; refPc[i] = '0; refTgt[i] = '0; refSt[i] = 2'b00;
    end
    rst = 1'b1; lkPc = '0; rsValid = 1'b0; rsPc = '0; rsTaken = 1'b0; rsTarget = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: nothing hits after reset
    step(32'h100, 0, 0, 0, 0, "R1");
    step(A, 0, 0, 0, 0, "R1");
    // R5 R8: taken miss allocates as strongly taken and reports mispredict
    step(C, 1, A, 1, 32'h2000, "R5_R8");
    // R2 R7: redirect to the stored target
    step(A, 0, 0, 0, 0, "R2_R7");
    // R3: one wrong guess keeps taken
    step(C, 1, A, 0, 32'h9999, "R3_R8");
    step(A, 0, 0, 0, 0, "R3");
    // R3 R6: second wrong guess flips; target unchanged
    step(C, 1, A, 0, 32'h7777, "R3_R6");
    step(A, 0, 0, 0, 0, "R3_R6");
    // R4 R6: taken from 00 goes to 01, target rewritten, still not taken
    step(C, 1, A, 1, 32'h3000, "R4_R6");
    step(A, 0, 0, 0, 0, "R4_R6");
    // R3: 01 not taken falls back to 00
    step(C, 1, A, 0, 32'h0, "R3");
    step(C, 1, A, 1, 32'h3000, "R3");
    step(C, 1, A, 1, 32'h3000, "R3");
    step(A, 0, 0, 0, 0, "R3_R7");
    // R8: taken with a new target mispredicts even when the direction matches
    step(C, 1, A, 1, 32'h4000, "R8");
    step(C, 1, A, 1, 32'h4000, "R8");
    step(A, 0, 0, 0, 0, "R6_R7");
    // R3: 10 taken returns to 11
    step(C, 1, A, 0, 32'h0, "R3");
    step(C, 1, A, 1, 32'h4000, "R3_R8");
    step(A, 0, 0, 0, 0, "R3");
    // R2 R5: an aliasing PC misses, then evicts A
    step(B, 0, 0, 0, 0, "R2");
    step(C, 1, B, 0, 32'h5000, "R5");
    step(A, 0, 0, 0, 0, "R5");
    step(B, 0, 0, 0, 0, "R5");
    // R9: lookup of B in the resolve cycle sees the older record
    step(B, 1, B, 1, 32'h6000, "R9");
    step(B, 1, B, 1, 32'h6000, "R9");
    step(B, 0, 0, 0, 0, "R9");
    // R2 R5: fill every index with a distinct branch and look each up
    for (int i = 0; i < DEPTH; i++)
      step(32'h100, 1, 32'h8000 + PC_W'(i * 4), i[0], 32'hA000 + PC_W'(i * 16), "R5");
    for (int i = 0; i < DEPTH; i++)
      step(32'h8000 + PC_W'(i * 4), 0, 0, 0, 0, "R2");
    // R1: reset clears all records
    @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) refValid[i] = 1'b0;
    step(32'h8004, 0, 0, 0, 0, "R1");
    step(B, 0, 0, 0, 0, "R1");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    finishRun();
  end

endmodule